// File: doc/BRIEF.md
# Fall-Through FIFO with Parallel and Bit-Serial Ports

This block is a first-in first-out buffer of 32 bytes built as a chain of stages rather than a RAM with pointers. A word written at the input end moves one stage per clock toward the output end. It stops when the stage ahead of it is occupied, so the oldest stored word always ends up waiting at the output. The writer and the reader work independently. Both run on one system clock, and every control input is a single-cycle strobe.

Each side can move whole bytes or single bits. On the write side a word can be loaded in parallel, or it can be assembled from eight bit strobes taken from data line 0. The assembled byte then enters the chain without any further action. On the read side the waiting word can be taken away in one strobe, or it can be shifted out bit by bit on output line 7. After the eighth bit the next word moves up. The block reports input-ready, output-ready and a half-full flag. An active-low clear empties it, and an output enable gates the data outputs.

Top module: `ripple_fifo`

## Requirements
- R1: While `clearN` is low and after it returns high, `outReady` is 0, `inReady` is 1 and `halfFlag` is 0. Any partly assembled or partly shifted serial byte is discarded.
- R2: A `loadPar` strobe into an empty FIFO stores `dIn`, and `outReady` first reads 1 after the 32nd rising edge, counting the edge that sampled the strobe as the first. After the 31st edge it still reads 0.
- R3: With `outEn` high, `qOut` shows the oldest stored word, and a `takePar` strobe removes it. Words leave in the order they were written, including when writes and reads happen in the same cycles.
- R4: `inReady` is 0 once the 32 stages are all occupied, and a write strobe while `inReady` is 0 stores nothing.
- R5: `halfFlag` is 1 exactly when more than 15 words are stored, sampled when no transfer is in flight.
- R6: Each `loadSer` strobe shifts `dIn[0]` into an input assembly register, first bit as the most significant. After the 8th strobe the byte enters the chain. Seven strobes alone store nothing.
- R7: `qOut[7]` shows the most significant remaining bit of the output word. Each `takeSer` strobe shifts the word one place toward bit 7. The 8th strobe removes the word.
- R8: A `loadPar` strobe while a serial input byte is partly assembled is ignored. A `takePar` strobe while a serial output byte is partly shifted is ignored.
- R9: `takePar` or `takeSer` while `outReady` is 0 has no effect.
- R10: When `outEn` is 0, `qOut` reads 0. `outReady`, `inReady` and `halfFlag` do not depend on `outEn`.
- R11: When an accepted `loadPar` and a `loadSer` come in the same cycle, the parallel load wins and the serial bit is dropped. The same holds for `takePar` over `takeSer` on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clearN | input | 1 | Active-low asynchronous clear |
| dIn | input | 8 | Parallel write byte; bit 0 is also the serial input |
| loadPar | input | 1 | Strobe: load `dIn` as one word |
| loadSer | input | 1 | Strobe: shift `dIn[0]` into the input assembly register |
| takePar | input | 1 | Strobe: remove the word at the output |
| takeSer | input | 1 | Strobe: shift the output word one bit toward `qOut[7]` |
| outEn | input | 1 | Data output enable |
| qOut | output | 8 | Output word; bit 7 is the serial output |
| outReady | output | 1 | A word waits at the output |
| inReady | output | 1 | Input stage can accept a word |
| halfFlag | output | 1 | More than 15 words stored |

## Verification
Two things can fall in the same cycle. A word can enter the input stage while another leaves the output stage. A parallel strobe can also arrive together with a serial strobe on the same side. The first case is provoked by a streaming run that writes whenever `inReady` is high and reads whenever `outReady` is high. Every word removed is compared against a queue model kept in the bench. The second case is provoked by raising both strobes together. The outcome is judged from the data: a later eight-bit serial byte must arrive intact, and a later parallel read must be accepted, which fails if the losing strobe had been counted.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

  // Per-cycle commands from the control to the stage chain.
  typedef struct packed {
    logic push;   // load a word into the input stage
    logic pop;    // empty the output stage
    logic shift;  // move the output word one bit toward the serial pin
  } fifo_strobe_t;

endpackage

// File: rtl/ripple_fifo_ctrl.sv
module ripple_fifo_ctrl
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             loadPar,
  input  logic             loadSer,
  input  logic             takePar,
  input  logic             takeSer,
  input  logic             headValid,
  input  logic             tailValid,
  output fifo_strobe_t     strobe,
  output logic [WIDTH-1:0] pushData
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] inCnt;
  logic [CNT_W-1:0] outCnt;
  logic [WIDTH-1:0] inShift;
  logic [WIDTH-1:0] serWord;
  logic parIn, serIn, serInDone;
  logic parOut, serOut, serOutDone;

  always_comb begin
    // write side: parallel wins only between serial bytes
    parIn     = loadPar && !headValid && (inCnt == '0);
    serIn     = loadSer && !headValid && !parIn;
    serWord   = {inShift[WIDTH-2:0], dIn[0]};
    serInDone = serIn && (inCnt == LAST_BIT);
    // read side
    parOut     = takePar && tailValid && (outCnt == '0);
    serOut     = takeSer && tailValid && !parOut;
    serOutDone = serOut && (outCnt == LAST_BIT);

    strobe.push  = parIn || serInDone;
    strobe.pop   = parOut || serOutDone;
    strobe.shift = serOut && !serOutDone;
    pushData     = parIn ? dIn : serWord;
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) begin
      inCnt   <= '0;
      outCnt  <= '0;
      inShift <= '0;
    end else begin
      if (serIn) begin
        inShift <= serWord;
        inCnt   <= serInDone ? '0 : inCnt + 1'b1;
      end
      if (serOut) begin
        outCnt <= serOutDone ? '0 : outCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ripple_fifo_path.sv
module ripple_fifo_path
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 32,
  parameter int FLAG_LEVEL = 15
) (
  input  logic             clk,
  input  logic             clearN,
  input  fifo_strobe_t     strobe,
  input  logic [WIDTH-1:0] pushData,
  input  logic             outEn,
  output logic             headValid,
  output logic             tailValid,
  output logic [WIDTH-1:0] qOut,
  output logic             halfFlag
);

  localparam int TAIL  = DEPTH - 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] valid, validNext;
  logic [WIDTH-1:0] data [DEPTH];
  logic [WIDTH-1:0] dataNext [DEPTH];
  logic [DEPTH-1:0] adv;
  logic [OCC_W-1:0] occupancy;

  // a stage hands its word on when the stage ahead is empty
  for (genvar i = 0; i < DEPTH; i++) begin : g_adv
    if (i == TAIL) begin : g_tail
      assign adv[i] = 1'b0;
    end else begin : g_body
      assign adv[i] = valid[i] && !valid[i+1];
    end
  end

  always_comb begin
    validNext = valid;
    dataNext  = data;
    // input stage
    if (strobe.push) begin
      validNext[0] = 1'b1;
      dataNext[0]  = pushData;
    end else if (adv[0]) begin
      validNext[0] = 1'b0;
    end
    // middle stages
    for (int k = 1; k < TAIL; k++) begin
      if (adv[k-1]) begin
        validNext[k] = 1'b1;
        dataNext[k]  = data[k-1];
      end else if (adv[k]) begin
        validNext[k] = 1'b0;
      end
    end
    // output stage
    if (adv[TAIL-1]) begin
      validNext[TAIL] = 1'b1;
      dataNext[TAIL]  = data[TAIL-1];
    end else if (strobe.pop) begin
      validNext[TAIL] = 1'b0;
    end else if (strobe.shift) begin
      dataNext[TAIL] = {data[TAIL][WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) valid <= '0;
    else         valid <= validNext;
  end

  always_ff @(posedge clk) begin
    data <= dataNext;
  end

  always_comb begin
    occupancy = '0;
    for (int k = 0; k < DEPTH; k++) occupancy += OCC_W'(valid[k]);
  end

  assign halfFlag  = occupancy > OCC_W'(FLAG_LEVEL);
  assign headValid = valid[0];
  assign tailValid = valid[TAIL];
  assign qOut      = outEn ? data[TAIL] : '0;

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 32,
  parameter int FLAG_LEVEL = 15
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             loadPar,
  input  logic             loadSer,
  input  logic             takePar,
  input  logic             takeSer,
  input  logic             outEn,
  output logic [WIDTH-1:0] qOut,
  output logic             outReady,
  output logic             inReady,
  output logic             halfFlag
);

  fifo_strobe_t     strobe;
  logic [WIDTH-1:0] pushData;
  logic             headValid;
  logic             tailValid;

  ripple_fifo_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .clearN(clearN), .dIn(dIn),
    .loadPar(loadPar), .loadSer(loadSer),
    .takePar(takePar), .takeSer(takeSer),
    .headValid(headValid), .tailValid(tailValid),
    .strobe(strobe), .pushData(pushData)
  );

  ripple_fifo_path #(.WIDTH(WIDTH), .DEPTH(DEPTH), .FLAG_LEVEL(FLAG_LEVEL)) u_path (
    .clk(clk), .clearN(clearN), .strobe(strobe), .pushData(pushData),
    .outEn(outEn), .headValid(headValid), .tailValid(tailValid),
    .qOut(qOut), .halfFlag(halfFlag)
  );

  assign outReady = tailValid;
  assign inReady  = !headValid;

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadPar,
  input logic             loadSer,
  input logic             takePar,
  input logic             takeSer,
  input logic             outEn,
  input logic [WIDTH-1:0] qOut,
  input logic             outReady,
  input logic             inReady,
  input logic             halfFlag
);

  // R4: the input stage fills only because of a write strobe
  p_ir_fall_r4: assert property (@(posedge clk) disable iff (!clearN)
    $fell(inReady) |-> $past(loadPar || loadSer));

  // R9: the output empties only because of a read strobe
  p_or_fall_r9: assert property (@(posedge clk) disable iff (!clearN)
    $fell(outReady) |-> $past(takePar || takeSer));

  // R5: crossing the half mark upward needs a write
  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!clearN)
    $rose(halfFlag) |-> $past(loadPar || loadSer));

  // R5: crossing the half mark downward needs a read
  p_flag_fall_r5: assert property (@(posedge clk) disable iff (!clearN)
    $fell(halfFlag) |-> $past(takePar || takeSer));

  // R3: the waiting word holds still while nobody reads it
  p_q_hold_r3: assert property (@(posedge clk) disable iff (!clearN)
    (outReady && $past(outReady) && !$past(takePar || takeSer) && outEn && $past(outEn))
      |-> $stable(qOut));

endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clearN(clearN), .loadPar(loadPar), .loadSer(loadSer),
  .takePar(takePar), .takeSer(takeSer), .outEn(outEn), .qOut(qOut),
  .outReady(outReady), .inReady(inReady), .halfFlag(halfFlag)
);

// File: tb/ripple_fifo_tb.sv
module ripple_fifo_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clearN = 1'b0;
  logic [7:0] dIn = '0;
  logic       loadPar = 1'b0, loadSer = 1'b0, takePar = 1'b0, takeSer = 1'b0;
  logic       outEn = 1'b1;
  logic [7:0] qOut;
  logic       outReady, inReady, halfFlag;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [0:1023];
  int wr = 0;
  int rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_fifo u_dut (
    .clk(clk), .clearN(clearN), .dIn(dIn), .loadPar(loadPar), .loadSer(loadSer),
    .takePar(takePar), .takeSer(takeSer), .outEn(outEn), .qOut(qOut),
    .outReady(outReady), .inReady(inReady), .halfFlag(halfFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePar(input logic [7:0] v);
    dIn = v; loadPar = 1'b1; @(negedge clk); loadPar = 1'b0;
  endtask

  task automatic pulseSer(input logic b);
    dIn = {7'b0, b}; loadSer = 1'b1; @(negedge clk); loadSer = 1'b0;
  endtask

  task automatic pulseTake;
    takePar = 1'b1; @(negedge clk); takePar = 1'b0;
  endtask

  task automatic pulseShift;
    takeSer = 1'b1; @(negedge clk); takeSer = 1'b0;
  endtask

  task automatic waitOut(input string req);
    int n = 0;
    while (!outReady && n < 200) begin @(negedge clk); n++; end
    if (!outReady) check(req, "output never ready", 0, 1);
  endtask

  function automatic logic [7:0] fillVal(input int k);
    return 8'((k * 29 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(3);
    check("R1", "outReady in reset", int'(outReady), 0);
    check("R1", "inReady in reset", int'(inReady), 1);
    clearN = 1'b1;
    cyc(1);
    check("R1", "outReady after reset", int'(outReady), 0);
    check("R1", "inReady after reset", int'(inReady), 1);
    check("R1", "halfFlag after reset", int'(halfFlag), 0);

    // R2: fall-through latency into an empty FIFO
    pulsePar(8'hA5);
    cyc(30);
    check("R2", "outReady after 31 edges", int'(outReady), 0);
    cyc(1);
    check("R2", "outReady after 32 edges", int'(outReady), 1);
    check("R3", "first word", int'(qOut), 8'hA5);
    pulseTake;
    check("R3", "outReady after take", int'(outReady), 0);

    // R9: reads on an empty FIFO do nothing
    pulseTake;
    pulseShift;
    check("R9", "inReady after empty reads", int'(inReady), 1);
    pulsePar(8'h3C);
    waitOut("R9");
    check("R9", "word after empty reads", int'(qOut), 8'h3C);
    pulseShift;
    check("R9", "msb after one shift", int'(qOut[7]), 0);
    cyc(6);
    // 7 more shifts finish the word; a shift before arrival would leave it misaligned
    repeat (7) pulseShift;
    check("R9", "empty after serial drain", int'(outReady), 0);

    // R4 / R5: fill to capacity, then drain with a sweep on the flag
    for (int k = 0; k < 32; k++) begin
      while (!inReady) @(negedge clk);
      pulsePar(fillVal(k));
    end
    cyc(40);
    check("R4", "inReady when full", int'(inReady), 0);
    check("R5", "halfFlag when full", int'(halfFlag), 1);
    pulsePar(8'hFF);
    pulseSer(1'b1);
    for (int k = 0; k < 32; k++) begin
      waitOut("R3");
      cyc(34);
      check("R5", $sformatf("halfFlag with %0d words", 32 - k), int'(halfFlag), int'((32 - k) > 15));
      check("R3", $sformatf("order word %0d", k), int'(qOut), int'(fillVal(k)));
      pulseTake;
    end
    cyc(40);
    check("R4", "write while full stored nothing", int'(outReady), 0);
    check("R5", "halfFlag when empty", int'(halfFlag), 0);

    // R6 / R8: serial assembly with an interfering parallel load
    for (int j = 0; j < 7; j++) begin
      pulseSer(1'((8'hB2 >> (7 - j)) & 1));
      if (j == 2) pulsePar(8'h77);
    end
    cyc(40);
    check("R6", "seven bits store nothing", int'(outReady), 0);
    check("R8", "mid-byte parallel load ignored", int'(outReady), 0);
    pulseSer(1'b0);
    waitOut("R6");
    check("R6", "assembled byte", int'(qOut), 8'hB2);
    pulseTake;
    cyc(40);
    check("R8", "no extra word", int'(outReady), 0);

    // R7 / R8: serial output with an interfering parallel take
    pulsePar(8'hC6);
    waitOut("R7");
    for (int j = 0; j < 8; j++) begin
      check("R7", $sformatf("serial bit %0d", j), int'(qOut[7]), int'((8'hC6 >> (7 - j)) & 1));
      pulseShift;
      if (j == 2) begin
        pulseTake;
        check("R8", "mid-byte take ignored", int'(outReady), 1);
      end
    end
    check("R7", "word gone after 8 shifts", int'(outReady), 0);

    // R10: output enable gates data only
    pulsePar(8'h5A);
    waitOut("R10");
    outEn = 1'b0;
    cyc(1);
    check("R10", "qOut disabled", int'(qOut), 0);
    check("R10", "outReady disabled", int'(outReady), 1);
    check("R10", "inReady disabled", int'(inReady), 1);
    outEn = 1'b1;
    cyc(1);
    check("R10", "qOut enabled", int'(qOut), 8'h5A);
    pulseTake;

    // R11: parallel load wins over serial bit
    dIn = 8'h81; loadPar = 1'b1; loadSer = 1'b1;
    @(negedge clk);
    loadPar = 1'b0; loadSer = 1'b0;
    waitOut("R11");
    check("R11", "parallel word won", int'(qOut), 8'h81);
    pulseTake;
    for (int j = 0; j < 8; j++) pulseSer(1'((8'h4E >> (7 - j)) & 1));
    waitOut("R11");
    check("R11", "serial byte intact", int'(qOut), 8'h4E);
    pulseTake;

    // R11: parallel take wins over serial shift
    pulsePar(8'hF0);
    cyc(1);
    pulsePar(8'h0F);
    waitOut("R11");
    takePar = 1'b1; takeSer = 1'b1;
    @(negedge clk);
    takePar = 1'b0; takeSer = 1'b0;
    waitOut("R11");
    cyc(3);
    check("R11", "second word unshifted", int'(qOut), 8'h0F);
    pulseTake;
    check("R11", "take accepted after tie", int'(outReady), 0);

    // R3: streaming with writes and reads in the same cycles
    wr = 0; rd = 0;
    for (int c = 0; c < 300; c++) begin
      loadPar = inReady && (c < 260);
      takePar = outReady;
      dIn = 8'((c * 37 + 11) & 255);
      if (takePar) begin
        check("R3", "stream order", int'(qOut), int'(model[rd]));
        rd++;
      end
      if (loadPar) begin
        model[wr] = dIn;
        wr++;
      end
      @(negedge clk);
    end
    loadPar = 1'b0; takePar = 1'b0;
    while (rd < wr) begin
      waitOut("R3");
      check("R3", "stream drain", int'(qOut), int'(model[rd]));
      rd++;
      pulseTake;
    end
    cyc(40);
    check("R3", "empty after stream", int'(outReady), 0);

    // R1: clear in the middle of serial bytes
    pulsePar(8'h11);
    pulseSer(1'b1);
    pulseSer(1'b1);
    clearN = 1'b0;
    cyc(1);
    clearN = 1'b1;
    cyc(1);
    check("R1", "cleared outReady", int'(outReady), 0);
    check("R1", "cleared inReady", int'(inReady), 1);
    for (int j = 0; j < 8; j++) pulseSer(1'((8'h69 >> (7 - j)) & 1));
    waitOut("R1");
    check("R1", "serial counter cleared", int'(qOut), 8'h69);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule